// File: doc/BRIEF.md
# Slow Peripheral Synchronous Bus Bridge

This block lets a processor whose bus normally finishes each cycle on a returned acknowledge talk to a slow peripheral that runs on a divided clock. It produces a free-running enable clock at one tenth of the system clock. When an address decoder marks the current cycle as a slow-peripheral access, the bridge waits for the next full enable period. For the whole of that period it asserts a valid-memory-address output. The peripheral then sees a stable address, and write data held for it.

On the falling edge of the enable clock that closes the period, read data from the peripheral is captured and a cycle-complete flag is raised toward the processor. No acknowledge from the peripheral is used: the enable timing alone ends the transfer. When the processor releases its address strobe, the valid-memory-address and cycle-complete outputs are withdrawn. This holds whether the transfer finished or not. Address decoding and the peripheral itself lie outside the block.

Top module: `slow_sync_bridge`

## Requirements
- R1: The enable output `eClk` repeats every 10 system clocks. It is low for 6 and high for 4. Counting from the first clock edge after reset is released, it is high exactly when the edge count modulo 10 is 6, 7, 8 or 9.
- R2: While reset is held and directly after it, `vmaN` is 1, `cycDone` is 0 and `eClk` is 0.
- R3: A request is `asN` = 0 and `vpaN` = 0, both active low, seen at a clock edge while the bridge is idle. Let c be the edge count modulo 10 just before the edge that samples the request. `vmaN` goes to 0 at the edge (10 − c) edges after the sampling edge counts as edge 1. This coincides with `eClk` falling.
- R4: `vmaN` stays 0 for exactly 10 clocks, which is one enable period. At the edge that ends it, `vmaN` returns to 1 and `cycDone` goes to 1, together with the next fall of `eClk`.
- R5: For a read (`rdWr` = 1 when the request is sampled), `cpuRdData` takes the value present on `periphRdData` just before the edge at which `eClk` falls to end the transfer period. It holds that value afterwards.
- R6: For a write (`rdWr` = 0), `periphWrData` shows the `cpuWrData` value sampled with the request, and `periphWrEn` is 1 exactly while `vmaN` is 0. For reads `periphWrEn` stays 0.
- R7: One clock edge after `asN` is seen at 1, `vmaN` is 1 and `cycDone` is 0. This also applies when the release comes at the edge that would otherwise complete the transfer: the release wins and `cycDone` never rises.
- R8: A cycle with `asN` = 0 but `vpaN` = 1 is not for this bridge. `vmaN` stays 1 and `cycDone` stays 0 for as long as it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| asN | input | 1 | Processor address strobe, active low |
| rdWr | input | 1 | Transfer direction, 1 = read, 0 = write |
| vpaN | input | 1 | Slow-peripheral select from the address decoder, active low |
| cpuWrData | input | DATA_W | Write data from the processor |
| periphRdData | input | DATA_W | Read data from the peripheral |
| eClk | output | 1 | Divided free-running enable clock |
| vmaN | output | 1 | Valid memory address toward the peripheral, active low |
| cycDone | output | 1 | Cycle complete toward the processor |
| cpuRdData | output | DATA_W | Read data captured for the processor |
| periphWrData | output | DATA_W | Write data held for the peripheral |
| periphWrEn | output | 1 | Write qualifier for the peripheral during the transfer period |

## Verification
Two events can fall on the same clock edge, and the bench provokes both.

- A request sampled in the last phase of the enable period is accepted on the very edge where `eClk` falls. Sweeping the request over every one of the ten phases places one case there. Each case is judged against a latency of 10 − c edges computed in the bench.
- The processor can release the address strobe just before the edge that would end the transfer. The bench does this by raising `asN` one clock before the expected completion. It then requires `vmaN` back at 1 with `cycDone` never rising, followed by a normal transfer to show the bridge recovered.

// File: rtl/slow_sync_bridge_pkg.sv
package slow_sync_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // request accepted: capture direction and write data
    logic capture;     // end of transfer period: capture read data
    logic xferActive;  // transfer period in progress
  } ctlStrobe_t;

endpackage

// File: rtl/sb_enable_gen.sv
module sb_enable_gen #(
  parameter int DIV     = 10,
  parameter int LOW_CNT = 6
) (
  input  logic clk,
  input  logic rstN,
  output logic eClk,
  output logic lastPhase
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] LOWV = CW'(LOW_CNT);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign eClk      = (phase >= LOWV);
  assign lastPhase = (phase == LAST);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import slow_sync_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       asN,
  input  logic       vpaN,
  input  logic       lastPhase,
  output logic       vmaN,
  output logic       cycDone,
  output ctlStrobe_t strobe
);
  bridgeState_t state, stateNext;
  logic reqSeen;

  assign reqSeen = !asN && !vpaN;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqSeen) stateNext = lastPhase ? ST_XFER : ST_WAIT;
      ST_WAIT: if (asN) stateNext = ST_IDLE;
               else if (lastPhase) stateNext = ST_XFER;
      ST_XFER: if (asN) stateNext = ST_IDLE;
               else if (lastPhase) stateNext = ST_DONE;
      ST_DONE: if (asN) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.loadReq    = (state == ST_IDLE) && reqSeen;
    strobe.capture    = (state == ST_XFER) && !asN && lastPhase;
    strobe.xferActive = (state == ST_XFER);
  end

  assign vmaN    = (state != ST_XFER);
  assign cycDone = (state == ST_DONE);
endmodule

// File: rtl/sb_datapath.sv
module sb_datapath
  import slow_sync_bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              rdWr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] periphRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] periphWrData,
  output logic              periphWrEn
);
  logic dirRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirRead      <= 1'b1;
      periphWrData <= '0;
    end else if (strobe.loadReq) begin
      dirRead      <= rdWr;
      periphWrData <= cpuWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          cpuRdData <= '0;
    else if (strobe.capture && dirRead) cpuRdData <= periphRdData;
  end

  assign periphWrEn = strobe.xferActive && !dirRead;
endmodule

// File: rtl/slow_sync_bridge.sv
module slow_sync_bridge
  import slow_sync_bridge_pkg::*;
#(
  parameter int DIV     = 10,
  parameter int LOW_CNT = 6,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asN,
  input  logic              rdWr,
  input  logic              vpaN,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] periphRdData,
  output logic              eClk,
  output logic              vmaN,
  output logic              cycDone,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] periphWrData,
  output logic              periphWrEn
);
  logic       lastPhase;
  ctlStrobe_t strobe;

  sb_enable_gen #(.DIV(DIV), .LOW_CNT(LOW_CNT)) i_enGen (
    .clk(clk), .rstN(rstN), .eClk(eClk), .lastPhase(lastPhase)
  );

  sb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .asN(asN), .vpaN(vpaN), .lastPhase(lastPhase),
    .vmaN(vmaN), .cycDone(cycDone), .strobe(strobe)
  );

  sb_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdWr(rdWr),
    .cpuWrData(cpuWrData), .periphRdData(periphRdData),
    .cpuRdData(cpuRdData), .periphWrData(periphWrData), .periphWrEn(periphWrEn)
  );
endmodule

// File: rtl/slow_sync_bridge_chk.sv
module slow_sync_bridge_chk #(
  parameter int DIV     = 10,
  parameter int LOW_CNT = 6
) (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic vpaN,
  input logic eClk,
  input logic vmaN,
  input logic cycDone,
  input logic periphWrEn
);
  localparam int HIGH_CNT = DIV - LOW_CNT;
  localparam int RW = $clog2(DIV + 1);

  logic [RW-1:0] hiRun;
  logic [RW-1:0] vmaRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun  <= '0;
      vmaRun <= '0;
    end else begin
      hiRun  <= eClk  ? RW'(hiRun + 1'b1)  : '0;
      vmaRun <= !vmaN ? RW'(vmaRun + 1'b1) : '0;
    end
  end

  AST_E_HIGH_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    hiRun <= RW'(HIGH_CNT)) else $error("enable high too long"); // R1

  AST_VMA_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vmaN) |-> $past(!asN && !vpaN)) else $error("vma without request"); // R8

  AST_VMA_AT_PERIOD_START: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vmaN) |-> $fell(eClk)) else $error("vma not at period start"); // R3

  AST_VMA_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    vmaRun <= RW'(DIV)) else $error("vma longer than a period"); // R4

  AST_DONE_AT_E_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycDone) |-> $fell(eClk) && $past(!vmaN)) else $error("done off timing"); // R4

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> vmaN && !cycDone) else $error("no release"); // R7

  AST_WREN_IN_XFER: assert property (@(posedge clk) disable iff (!rstN)
    periphWrEn |-> !vmaN) else $error("write enable outside transfer"); // R6
endmodule

bind slow_sync_bridge slow_sync_bridge_chk #(.DIV(DIV), .LOW_CNT(LOW_CNT)) i_chk (
  .clk(clk), .rstN(rstN), .asN(asN), .vpaN(vpaN), .eClk(eClk),
  .vmaN(vmaN), .cycDone(cycDone), .periphWrEn(periphWrEn)
);

// File: tb/test_slow_sync_bridge.sv
module test_slow_sync_bridge;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic asN = 1'b1, rdWr = 1'b1, vpaN = 1'b1;
  logic [DW-1:0] cpuWrData = '0, periphRdData = '0;
  logic eClk, vmaN, cycDone, periphWrEn;
  logic [DW-1:0] cpuRdData, periphWrData;

  int nChecks = 0, nFails = 0;
  int ph = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) ph <= 0;
    else       ph <= (ph == 9) ? 0 : ph + 1;
  end

  slow_sync_bridge i_slow_sync_bridge (
    .clk(clk), .rstN(rstN), .asN(asN), .rdWr(rdWr), .vpaN(vpaN),
    .cpuWrData(cpuWrData), .periphRdData(periphRdData),
    .eClk(eClk), .vmaN(vmaN), .cycDone(cycDone),
    .cpuRdData(cpuRdData), .periphWrData(periphWrData), .periphWrEn(periphWrEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
  endtask

  task automatic waitPhase(input int c);
    @(negedge clk);
    while (ph != c) @(negedge clk);
  endtask

  // full transfer requested at phase c
  task automatic transfer(input bit isRead, input int c, input logic [DW-1:0] base,
                          input logic [DW-1:0] wdata);
    int vmaAt, doneAt;
    vmaAt  = 10 - c;
    doneAt = 20 - c;
    waitPhase(c);
    asN = 1'b0; vpaN = 1'b0; rdWr = isRead; cpuWrData = wdata;
    periphRdData = base;
    for (int k = 1; k <= doneAt; k++) begin
      @(negedge clk);
      check("R3/R4 vmaN", 32'(vmaN), 32'((k >= vmaAt && k < doneAt) ? 1'b0 : 1'b1));
      check("R4 cycDone", 32'(cycDone), 32'(k >= doneAt));
      if (k == vmaAt) check("R3 eClk low at vma start", 32'(eClk), 32'd0);
      if (k == vmaAt) begin
        check("R6 periphWrEn", 32'(periphWrEn), 32'(!isRead));
        if (!isRead) check("R6 periphWrData", 32'(periphWrData), 32'(wdata));
      end
      if (k == doneAt && isRead)
        check("R5 cpuRdData", 32'(cpuRdData), 32'(DW'(base + DW'(19 - c))));
      periphRdData = DW'(base + DW'(k));
    end
    asN = 1'b1; vpaN = 1'b1;
    @(negedge clk);
    check("R7 vmaN after release", 32'(vmaN), 32'd1);
    check("R7 cycDone after release", 32'(cycDone), 32'd0);
    if (isRead) check("R5 read data held", 32'(cpuRdData), 32'(DW'(base + DW'(19 - c))));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 vmaN in reset", 32'(vmaN), 32'd1);
    check("R2 cycDone in reset", 32'(cycDone), 32'd0);
    check("R2 eClk in reset", 32'(eClk), 32'd0);
    rstN = 1'b1;
    check("R2 vmaN after reset", 32'(vmaN), 32'd1);

    // R1: enable waveform over several periods
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R1 eClk waveform", 32'(eClk), 32'(ph >= 6));
    end

    // R3 R4 R5: reads at every phase
    for (int c = 0; c < 10; c++)
      transfer(1'b1, c, DW'(16'h1000 * c + 16'h00A0), '0);

    // R6: writes at several phases
    for (int c = 0; c < 10; c += 3)
      transfer(1'b0, c, '0, DW'(16'hC300 + c));

    // R8: strobe without peripheral select
    waitPhase(2);
    asN = 1'b0; vpaN = 1'b1; rdWr = 1'b1;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      check("R8 vmaN stays high", 32'(vmaN), 32'd1);
      check("R8 cycDone stays low", 32'(cycDone), 32'd0);
    end
    asN = 1'b1;

    // R7: release one clock before completion
    waitPhase(3);
    asN = 1'b0; vpaN = 1'b0; rdWr = 1'b1;
    for (int k = 1; k < 20 - 3; k++) @(negedge clk);
    check("R7 vma active before abort", 32'(vmaN), 32'd0);
    asN = 1'b1; vpaN = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R7 vmaN after abort", 32'(vmaN), 32'd1);
      check("R7 no cycDone after abort", 32'(cycDone), 32'd0);
    end
    // recovery
    transfer(1'b1, 7, 16'h5500, '0);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule